// File: doc/BRIEF.md
# HI/LO Multiply-Accumulate Unit

This unit is the arithmetic core for a family of multiply and multiply-accumulate operations. Each operation multiplies two 64-bit register operands and then adds the product to, or subtracts it from, either zero or the current accumulator. The 64-bit sum can be clamped to a 32-bit range. The result goes back into a pair of 64-bit accumulator registers, HI and LO. The caller also receives a destination-register write value with its enable.

The accumulator has two layouts. In the wide layout, LO alone holds all 64 bits. In the split layout, the low words of HI and LO together form the accumulator. Operands are checked for canonical form before anything is committed. A malformed operand raises a flag and leaves all state alone.

Mode flags can come straight from ports. When the `HAS_DECODER` parameter is set, they are instead taken from a 32-bit instruction word by an internal decoder. In that case the destination index also comes from the instruction.

Top module: `mac_hilo_unit`

## Requirements
- R1: While reset is held, and right after it, HI, LO, the write enable and the bad-operand flag all read zero.
- R2: The left-hand value depends on the mode. With accumulate off it is zero. In the wide layout it is all 64 bits of LO. In the split layout it is HI[31:0] placed above LO[31:0].
- R3: The product is the 64-bit product of the low 32 bits of each operand. Those bits are zero-extended when unsigned is set and sign-extended otherwise.
- R4: The raw result is the left-hand value plus the product, or minus it when subtract is set, taken modulo 2^64.
- R5: With saturate set and unsigned clear, a raw result that is not the sign extension of its own low 32 bits is clamped. It becomes 0x000000007FFFFFFF when bit 63 is 0 and 0xFFFFFFFF80000000 when bit 63 is 1.
- R6: With saturate and unsigned both set, any 1 in bits 63:32 of the raw result turns the result into all ones. Otherwise the result passes through unchanged.
- R7: In the wide layout, LO takes the whole result and HI keeps its value.
- R8: In the split layout, LO becomes the sign extension of result[31:0] and HI becomes the sign extension of result[63:32].
- R9: The clock edge that commits an operation also registers the destination write. A write happens only when the destination index is nonzero. The write value is the new HI when HI-select is set and the new LO otherwise.
- R10: With short mode clear, an operand that differs from the sign extension of its own low 32 bits is invalid.
- R11: With short mode set, an operand is invalid when it differs from the extension of its low 16 bits. That extension is zero extension when unsigned and sign extension when signed.
- R12: An invalid operand on a valid operation sets the bad-operand output for one cycle after the edge. HI, LO and the write enable are left unchanged.
- R13: Decoder, class A. Bits 31:26 must be 0, bits 8:7 must be 00 and bits 5:1 must be 10100. In this class, bit 0 selects the wide layout, bit 10 sets both saturate and short mode, bit 9 is HI-select and bit 6 is unsigned. Accumulate is always on and subtract always off. The destination is bits 15:11.
- R14: Decoder, class B. Bits 31:26 must be 0, bit 10 must be 0 and bits 5:1 must be 01100. Bits 8:6 pick the operation: 001 multiply, 011 negated multiply, 101 accumulate, 111 subtract-accumulate. Bit 9 is HI-select and bit 0 is unsigned. The layout is split, with no saturation and no short mode. Any other word changes no state and raises no flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation strobe |
| insn_i | input | INSN_W | Instruction word (decoder variant only) |
| acc_en | input | 1 | Accumulate onto the current value (flag variant) |
| hi_sel | input | 1 | Destination takes HI rather than LO (flag variant) |
| uns_en | input | 1 | Unsigned arithmetic (flag variant) |
| sat_en | input | 1 | Saturate the result (flag variant) |
| sub_en | input | 1 | Subtract the product (flag variant) |
| short_en | input | 1 | 16-bit operand mode (flag variant) |
| dbl_en | input | 1 | Wide accumulator layout (flag variant) |
| dest_i | input | IDX_W | Destination index (flag variant) |
| src_a | input | DATA_W | First operand |
| src_b | input | DATA_W | Second operand |
| hi_o | output | DATA_W | HI register |
| lo_o | output | DATA_W | LO register |
| wr_en_o | output | 1 | Destination write enable |
| wr_idx_o | output | IDX_W | Destination index of the write |
| wr_data_o | output | DATA_W | Destination write value |
| bad_op_o | output | 1 | Invalid-operand flag |

## Verification
Two things can land on the same operation: saturation of an overflowing sum, and the destination write of HI. A single accumulate then has to clamp the value, re-split it and pick one half for the write, all at one edge. A second such case pairs an operand that fails the canonical check with an accumulate that would otherwise overflow. The bench provokes both with directed corner cases and with a random mix of modes, operands and occasional malformed 64-bit values. It judges each committed edge against a reference model that tracks HI and LO independently. For the malformed case, the bench requires the flag to be raised and no state to change.

// File: rtl/mac_pkg.sv
package mac_pkg;
   typedef struct packed {
      logic acc;
      logic hisel;
      logic uns;
      logic sat;
      logic sub;
      logic shrt;
      logic dbl;
   } mac_mode_t;
endpackage

// File: rtl/mac_decode.sv
module mac_decode
   import mac_pkg::*;
#(
   parameter int INSN_W = 32,
   parameter int IDX_W  = 5
) (
   input  logic [INSN_W-1:0] insn,
   output mac_mode_t         mode,
   output logic [IDX_W-1:0]  dest,
   output logic              hit
);
   logic is_zero_major;
   logic class_a;
   logic class_b;
   logic unused_fields;

   assign is_zero_major = (insn[31:26] == 6'b0);
   assign class_a = is_zero_major && (insn[5:1] == 5'b10100) && (insn[8:7] == 2'b00);
   assign class_b = is_zero_major && (insn[5:1] == 5'b01100) && !insn[10] && insn[6];
   assign unused_fields = ^insn[25:16];

   always_comb begin
      mode = '0;
      hit  = class_a || class_b;
      dest = insn[15:11];
      if (class_a) begin
         mode.acc   = 1'b1;
         mode.hisel = insn[9];
         mode.uns   = insn[6];
         mode.sat   = insn[10];
         mode.shrt  = insn[10];
         mode.dbl   = insn[0];
      end else if (class_b) begin
         mode.acc   = insn[8];
         mode.sub   = insn[7];
         mode.hisel = insn[9];
         mode.uns   = insn[0];
      end
   end
endmodule

// File: rtl/mac_opchk.sv
module mac_opchk #(
   parameter int DATA_W  = 64,
   parameter int SHORT_W = 16
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              uns,
   input  logic              shrt,
   output logic              bad
);
   localparam int HALF_W = DATA_W / 2;

   function automatic logic canon(input logic [DATA_W-1:0] v, input logic u, input logic s);
      logic [DATA_W-1:0] ref_v;
      if (!s)
         ref_v = {{(DATA_W-HALF_W){v[HALF_W-1]}}, v[HALF_W-1:0]};
      else if (u)
         ref_v = {{(DATA_W-SHORT_W){1'b0}}, v[SHORT_W-1:0]};
      else
         ref_v = {{(DATA_W-SHORT_W){v[SHORT_W-1]}}, v[SHORT_W-1:0]};
      return v == ref_v;
   endfunction

   assign bad = !canon(a, uns, shrt) || !canon(b, uns, shrt);
endmodule

// File: rtl/mac_mult.sv
module mac_mult #(
   parameter int DATA_W = 64
) (
   input  logic [DATA_W-1:0] a,
   input  logic [DATA_W-1:0] b,
   input  logic              uns,
   output logic [DATA_W-1:0] prod
);
   localparam int HALF_W = DATA_W / 2;

   logic [DATA_W-1:0] xa;
   logic [DATA_W-1:0] xb;
   logic              unused_upper;

   assign unused_upper = ^{a[DATA_W-1:HALF_W], b[DATA_W-1:HALF_W]};
   assign xa = uns ? {{HALF_W{1'b0}}, a[HALF_W-1:0]} : {{HALF_W{a[HALF_W-1]}}, a[HALF_W-1:0]};
   assign xb = uns ? {{HALF_W{1'b0}}, b[HALF_W-1:0]} : {{HALF_W{b[HALF_W-1]}}, b[HALF_W-1:0]};
   assign prod = xa * xb;
endmodule

// File: rtl/mac_accum.sv
module mac_accum
   import mac_pkg::*;
#(
   parameter int DATA_W = 64
) (
   input  mac_mode_t         mode,
   input  logic [DATA_W-1:0] hi,
   input  logic [DATA_W-1:0] lo,
   input  logic [DATA_W-1:0] prod,
   output logic [DATA_W-1:0] nxt_hi,
   output logic [DATA_W-1:0] nxt_lo
);
   localparam int HALF_W = DATA_W / 2;
   localparam logic [DATA_W-1:0] S_MAX = {{(HALF_W+1){1'b0}}, {(HALF_W-1){1'b1}}};
   localparam logic [DATA_W-1:0] S_MIN = {{(HALF_W+1){1'b1}}, {(HALF_W-1){1'b0}}};

   logic [DATA_W-1:0] lhs;
   logic [DATA_W-1:0] raw;
   logic [DATA_W-1:0] res;
   logic              s_fit;
   logic              u_fit;

   always_comb begin
      if (!mode.acc)     lhs = '0;
      else if (mode.dbl) lhs = lo;
      else               lhs = {hi[HALF_W-1:0], lo[HALF_W-1:0]};
   end

   assign raw   = mode.sub ? (lhs - prod) : (lhs + prod);
   assign s_fit = (raw == {{HALF_W{raw[HALF_W-1]}}, raw[HALF_W-1:0]});
   assign u_fit = ~|raw[DATA_W-1:HALF_W];

   always_comb begin
      res = raw;
      if (mode.sat && !mode.uns && !s_fit) res = raw[DATA_W-1] ? S_MIN : S_MAX;
      if (mode.sat &&  mode.uns && !u_fit) res = '1;
   end

   assign nxt_lo = mode.dbl ? res : {{HALF_W{res[HALF_W-1]}}, res[HALF_W-1:0]};
   assign nxt_hi = mode.dbl ? hi  : {{HALF_W{res[DATA_W-1]}}, res[DATA_W-1:HALF_W]};
endmodule

// File: rtl/mac_hilo_unit.sv
module mac_hilo_unit
   import mac_pkg::*;
#(
   parameter int DATA_W      = 64,
   parameter int SHORT_W     = 16,
   parameter int IDX_W       = 5,
   parameter int INSN_W      = 32,
   parameter bit HAS_DECODER = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              op_valid,
   input  logic [INSN_W-1:0] insn_i,
   input  logic              acc_en,
   input  logic              hi_sel,
   input  logic              uns_en,
   input  logic              sat_en,
   input  logic              sub_en,
   input  logic              short_en,
   input  logic              dbl_en,
   input  logic [IDX_W-1:0]  dest_i,
   input  logic [DATA_W-1:0] src_a,
   input  logic [DATA_W-1:0] src_b,
   output logic [DATA_W-1:0] hi_o,
   output logic [DATA_W-1:0] lo_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [DATA_W-1:0] wr_data_o,
   output logic              bad_op_o
);
   localparam int HALF_W = DATA_W / 2;

   if (DATA_W % 2 != 0) begin : g_w_even
      $error("DATA_W must be even");
   end
   if (SHORT_W < 1 || SHORT_W >= HALF_W) begin : g_w_short
      $error("SHORT_W must lie below half of DATA_W");
   end
   if (HAS_DECODER && (INSN_W != 32 || IDX_W != 5)) begin : g_w_dec
      $error("decoder variant needs a 32-bit word and 5-bit index");
   end

   mac_mode_t         mode;
   logic [IDX_W-1:0]  dest;
   logic              hit;
   logic              bad_c;
   logic              fire;
   logic [DATA_W-1:0] prod;
   logic [DATA_W-1:0] nxt_hi;
   logic [DATA_W-1:0] nxt_lo;

   if (HAS_DECODER) begin : g_dec
      logic unused_flags;
      assign unused_flags = ^{acc_en, hi_sel, uns_en, sat_en, sub_en, short_en, dbl_en, dest_i};
      mac_decode #(.INSN_W(INSN_W), .IDX_W(IDX_W)) dec_i (
         .insn (insn_i),
         .mode (mode),
         .dest (dest),
         .hit  (hit)
      );
   end else begin : g_flags
      logic unused_insn;
      assign unused_insn = ^insn_i;
      assign mode = '{acc: acc_en, hisel: hi_sel, uns: uns_en, sat: sat_en,
                      sub: sub_en, shrt: short_en, dbl: dbl_en};
      assign dest = dest_i;
      assign hit  = 1'b1;
   end

   mac_opchk #(.DATA_W(DATA_W), .SHORT_W(SHORT_W)) chk_i (
      .a    (src_a),
      .b    (src_b),
      .uns  (mode.uns),
      .shrt (mode.shrt),
      .bad  (bad_c)
   );

   mac_mult #(.DATA_W(DATA_W)) mul_i (
      .a    (src_a),
      .b    (src_b),
      .uns  (mode.uns),
      .prod (prod)
   );

   mac_accum #(.DATA_W(DATA_W)) acc_i (
      .mode   (mode),
      .hi     (hi_o),
      .lo     (lo_o),
      .prod   (prod),
      .nxt_hi (nxt_hi),
      .nxt_lo (nxt_lo)
   );

   assign fire = op_valid && hit && !bad_c;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hi_o      <= '0;
         lo_o      <= '0;
         wr_en_o   <= 1'b0;
         wr_idx_o  <= '0;
         wr_data_o <= '0;
         bad_op_o  <= 1'b0;
      end else begin
         if (fire) begin
            hi_o <= nxt_hi;
            lo_o <= nxt_lo;
         end
         wr_en_o   <= fire && (dest != '0);
         wr_idx_o  <= dest;
         wr_data_o <= mode.hisel ? nxt_hi : nxt_lo;
         bad_op_o  <= op_valid && hit && bad_c;
      end
   end

   // R7
   dbl_hi_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode.dbl) |=> (hi_o == $past(hi_o)));
   // R8
   split_lo_ext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && !mode.dbl) |=> (lo_o == {{HALF_W{lo_o[HALF_W-1]}}, lo_o[HALF_W-1:0]}));
   // R5
   sat_signed_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode.sat && !mode.uns && !mode.dbl) |=> (hi_o == {DATA_W{lo_o[HALF_W-1]}}));
   // R6
   sat_unsigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (fire && mode.sat && mode.uns && mode.dbl) |=> (&lo_o || ~|lo_o[DATA_W-1:HALF_W]));
   // R12
   bad_no_update_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bad_op_o |-> (!wr_en_o && hi_o == $past(hi_o) && lo_o == $past(lo_o)));
   // R9
   wr_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_idx_o != '0));
   // R9
   wr_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en_o |-> (wr_data_o == hi_o || wr_data_o == lo_o));
endmodule

// File: tb/mac_hilo_unit_tb_top.sv
`timescale 1ns/1ps
module mac_hilo_unit_tb_top;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        v_f = 1'b0, v_d = 1'b0;
   logic [31:0] insn = '0;
   logic        acc = 0, hs = 0, un = 0, st = 0, sb = 0, sh = 0, db = 0;
   logic [4:0]  dst = '0;
   logic [63:0] a = '0, b = '0;
   logic [63:0] f_hi, f_lo, f_wd, d_hi, d_lo, d_wd;
   logic        f_we, f_bad, d_we, d_bad;
   logic [4:0]  f_wi, d_wi;
   logic [63:0] m_hi = '0, m_lo = '0, n_hi = '0, n_lo = '0;
   int          n_chk = 0, n_fail = 0;
   bit          done = 0;

   always #2.5 clk = ~clk;

   mac_hilo_unit #(.HAS_DECODER(1'b0)) dut_i (
      .clk(clk), .rst_n(rst_n), .op_valid(v_f), .insn_i(insn),
      .acc_en(acc), .hi_sel(hs), .uns_en(un), .sat_en(st), .sub_en(sb),
      .short_en(sh), .dbl_en(db), .dest_i(dst), .src_a(a), .src_b(b),
      .hi_o(f_hi), .lo_o(f_lo), .wr_en_o(f_we), .wr_idx_o(f_wi),
      .wr_data_o(f_wd), .bad_op_o(f_bad));

   mac_hilo_unit #(.HAS_DECODER(1'b1)) dut_dec_i (
      .clk(clk), .rst_n(rst_n), .op_valid(v_d), .insn_i(insn),
      .acc_en(acc), .hi_sel(hs), .uns_en(un), .sat_en(st), .sub_en(sb),
      .short_en(sh), .dbl_en(db), .dest_i(dst), .src_a(a), .src_b(b),
      .hi_o(d_hi), .lo_o(d_lo), .wr_en_o(d_we), .wr_idx_o(d_wi),
      .wr_data_o(d_wd), .bad_op_o(d_bad));

   function automatic logic [63:0] sx32(input logic [31:0] v);
      return {{32{v[31]}}, v};
   endfunction

   function automatic logic [63:0] sx16(input logic [15:0] v);
      return {{48{v[15]}}, v};
   endfunction

   task automatic model(input logic c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db,
                        input logic [4:0] c_dst, input logic [63:0] x, y,
                        inout logic [63:0] hi, lo,
                        output logic e_bad, e_we, output logic [63:0] e_wd);
      logic [63:0] lhs, px, py, r;
      logic okx, oky;
      if (!c_sh) begin okx = (x == sx32(x[31:0])); oky = (y == sx32(y[31:0])); end
      else if (c_un) begin okx = (x[63:16] == 0); oky = (y[63:16] == 0); end
      else begin okx = (x == sx16(x[15:0])); oky = (y == sx16(y[15:0])); end
      e_bad = !(okx && oky);
      e_we = 1'b0;
      e_wd = '0;
      if (e_bad) return;
      lhs = !c_acc ? 64'd0 : (c_db ? lo : {hi[31:0], lo[31:0]});
      px = c_un ? {32'd0, x[31:0]} : sx32(x[31:0]);
      py = c_un ? {32'd0, y[31:0]} : sx32(y[31:0]);
      r = c_sb ? lhs - px * py : lhs + px * py;
      if (c_st && !c_un && r != sx32(r[31:0]))
         r = r[63] ? 64'hFFFF_FFFF_8000_0000 : 64'h0000_0000_7FFF_FFFF;
      if (c_st && c_un && r[63:32] != 0) r = '1;
      if (c_db) lo = r;
      else begin lo = sx32(r[31:0]); hi = sx32(r[63:32]); end
      e_we = (c_dst != 0);
      e_wd = c_hs ? hi : lo;
   endtask

   task automatic check(input bit ok, input string tag, input logic [63:0] act, exp_v);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp_v);
      end
   endtask

   task automatic compare(input string tag, input logic [63:0] hi, lo, wd,
                          input logic we, bad, input logic [4:0] wi,
                          input logic [63:0] ehi, elo, ewd,
                          input logic ewe, ebad, input logic [4:0] ewi);
      bit ok;
      ok = (hi == ehi) && (lo == elo) && (we == ewe) && (bad == ebad) &&
           (!ewe || (wd == ewd && wi == ewi));
      check(ok, {tag, " hi"}, hi, ehi);
      if (!ok) $display("     lo=%h/%h we=%0b/%0b bad=%0b/%0b wd=%h/%h",
                        lo, elo, we, ewe, bad, ebad, wd, ewd);
   endtask

   task automatic run_f(input logic c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db,
                        input logic [4:0] c_dst, input logic [63:0] x, y, input string tag);
      logic e_bad, e_we;
      logic [63:0] e_wd;
      {acc, hs, un, st, sb, sh, db} = {c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db};
      dst = c_dst; a = x; b = y; v_f = 1'b1;
      @(negedge clk);
      v_f = 1'b0;
      model(c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db, c_dst, x, y, m_hi, m_lo, e_bad, e_we, e_wd);
      compare(tag, f_hi, f_lo, f_wd, f_we, f_bad, f_wi, m_hi, m_lo, e_wd, e_we, e_bad, c_dst);
   endtask

   task automatic dec_ref(input logic [31:0] w, output logic rec,
                          output logic c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db);
      {rec, c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db} = '0;
      if (w[31:26] == 0 && w[5:1] == 5'b10100 && w[8:7] == 2'b00) begin
         rec = 1; c_acc = 1; c_hs = w[9]; c_un = w[6];
         c_st = w[10]; c_sh = w[10]; c_db = w[0];
      end else if (w[31:26] == 0 && w[5:1] == 5'b01100 && !w[10] && w[6]) begin
         rec = 1; c_acc = w[8]; c_sb = w[7]; c_hs = w[9]; c_un = w[0];
      end
   endtask

   function automatic logic [63:0] gen(input logic s, u);
      logic [31:0] r;
      r = $urandom;
      if ($urandom % 16 == 0) return {$urandom, $urandom};
      if (s) return u ? {48'd0, r[15:0]} : sx16(r[15:0]);
      return u && ($urandom % 2 == 1) ? sx32({1'b1, r[30:0]}) : sx32(r);
   endfunction

   task automatic run_d(input logic [31:0] w, input logic [63:0] x, y, input string tag);
      logic rec, c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db, e_bad, e_we;
      logic [63:0] e_wd;
      insn = w; a = x; b = y; v_d = 1'b1;
      @(negedge clk);
      v_d = 1'b0;
      dec_ref(w, rec, c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db);
      if (rec) model(c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db, w[15:11], x, y, n_hi, n_lo, e_bad, e_we, e_wd);
      else begin e_bad = 0; e_we = 0; e_wd = '0; end
      compare(tag, d_hi, d_lo, d_wd, d_we, d_bad, d_wi, n_hi, n_lo, e_wd, e_we, e_bad, w[15:11]);
   endtask

   function automatic logic [31:0] rand_insn();
      logic [31:0] r;
      logic [2:0] k, opsel;
      r = $urandom;
      k = 3'($urandom % 8);
      opsel = {r[1:0], 1'b1};
      if (k < 4) return {6'd0, r[25:11], 2'b00, r[6], 5'b10100, r[0]};
      if (k < 7) return {6'd0, r[25:11], 1'b0, r[9], opsel, 5'b01100, r[2]};
      return r;
   endfunction

   initial begin
      #1ms;
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog expired actual=0 expected=1");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(f_hi == 0 && f_lo == 0 && !f_we && !f_bad, "R1 reset", f_hi | f_lo, 64'd0);
      rst_n = 1'b1;
      @(negedge clk);
      check(d_hi == 0 && d_lo == 0 && !d_we && !d_bad, "R1 after reset", d_hi | d_lo, 64'd0);

      // R3 signed and unsigned products, split layout
      run_f(0,0,0,0,0,0,0, 5'd3, sx32(-32'sd3), 64'd5, "R3 signed mul");
      run_f(0,1,1,0,0,0,0, 5'd4, '1, 64'd2, "R3 unsigned mul hi");
      // R2 split accumulate uses HI[31:0]:LO[31:0]
      run_f(1,1,0,0,0,0,0, 5'd1, 64'd7, 64'd9, "R2 split acc");
      // R4 subtract
      run_f(1,0,0,0,1,0,0, 5'd2, 64'd100, 64'd100, "R4 subtract");
      // R7 wide layout keeps HI
      run_f(0,0,0,0,0,0,1, 5'd6, 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R7 wide mul");
      run_f(1,1,0,0,0,0,1, 5'd6, 64'h1234, 64'h10, "R2 wide acc R9 hi");
      // R5 signed saturation both directions
      run_f(0,0,0,1,0,0,0, 5'd7, 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R5 clamp high");
      run_f(0,1,0,1,0,0,0, 5'd7, sx32(32'h8000_0001), 64'h7FFF_FFFF, "R5 clamp low");
      // R6 unsigned saturation and pass-through
      run_f(0,0,1,1,0,0,1, 5'd8, 64'h7FFF_FFFF, 64'h7FFF_FFFF, "R6 unsigned sat");
      run_f(0,0,1,1,0,1,1, 5'd8, 64'h0000_FFFF, 64'h0000_0003, "R6 unsigned fits");
      // R9 index zero writes nothing
      run_f(0,0,0,0,0,0,0, 5'd0, 64'd4, 64'd4, "R9 idx zero");
      // R10 non-canonical 32-bit operand
      run_f(1,0,0,0,0,0,0, 5'd9, 64'h0000_0001_0000_0000, 64'd1, "R10 bad wide operand");
      // R11 short mode, signed vs unsigned view of 0x8000
      run_f(0,0,0,0,0,1,0, 5'd9, 64'h8000, 64'd1, "R11 short signed bad");
      run_f(0,0,1,0,0,1,0, 5'd9, 64'h8000, 64'd2, "R11 short unsigned ok");
      // R12 bad operand during an overflowing saturated accumulate
      run_f(1,1,0,1,0,0,0, 5'd5, 64'h1_7FFF_FFFF, 64'h7FFF_FFFF, "R12 bad wins over sat");

      // R13 class A, saturate forces short mode
      run_d({6'd0, 10'd0, 5'd3, 1'b0, 1'b0, 2'b00, 1'b0, 6'b101001}, 64'd6, 64'd7, "R13 wide macc");
      run_d({6'd0, 10'd0, 5'd3, 1'b1, 1'b1, 2'b00, 1'b0, 6'b101000}, 64'h1_0000, 64'd2, "R13 sat short bad");
      run_d({6'd0, 10'd0, 5'd3, 1'b1, 1'b1, 2'b00, 1'b1, 6'b101000}, 64'hFFFF, 64'hFFFF, "R13 sat short uns");
      // R14 class B operations and an unrecognized word
      run_d({6'd0, 10'd0, 5'd4, 1'b0, 1'b0, 3'b011, 6'b011000}, 64'd5, 64'd5, "R14 negated mul");
      run_d({6'd0, 10'd0, 5'd4, 1'b0, 1'b1, 3'b111, 6'b011000}, 64'd2, 64'd3, "R14 msac hi");
      run_d({6'd0, 10'd0, 5'd4, 1'b0, 1'b0, 3'b010, 6'b011000}, 64'd2, 64'd3, "R14 unknown opsel");

      for (int i = 0; i < 400; i++) begin
         logic [6:0] f;
         f = 7'($urandom);
         run_f(f[6], f[5], f[4], f[3], f[2], f[1], f[0], 5'($urandom),
               gen(f[1], f[4]), gen(f[1], f[4]), "R4 random flags");
      end
      for (int i = 0; i < 400; i++) begin
         logic [31:0] w;
         logic rec, c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db;
         w = rand_insn();
         dec_ref(w, rec, c_acc, c_hs, c_un, c_st, c_sb, c_sh, c_db);
         run_d(w, gen(c_sh, c_un), gen(c_sh, c_un), "R14 random decode");
      end

      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule